// File: doc/BRIEF.md
# Pointer-based register access controller

This block is the byte-level transaction engine that sits behind a two-wire serial host port. The bus physical layer, already stripped away, hands it transaction framing pulses (start, with a read/write direction, and stop), received bytes, and one-cycle read requests. It answers each read request one cycle later with a data byte. The first byte of every write transaction loads an 8-bit address pointer. Each later byte is stored at the location the pointer selects, and read transactions return bytes from that location.

Pointer value zero is reserved for the filter coefficient store. While the pointer is zero, each data byte goes into the next slot of a 196-entry coefficient memory, and the pointer stays put. The slot index restarts at zero on every transaction start. A byte beyond the last slot is dropped and flagged. Any nonzero pointer addresses one register, and the pointer advances after each byte, wrapping from 255 to 1. Two status registers, at addresses 12 and 13, collect event bits. They may only be read as the first byte of a read transaction. A burst read that runs into them gets 0x00 and an error pulse, and their contents are left intact. A clean read clears their clear-on-read bits.

The filter datapath reads the coefficient memory through a separate combinational index port.

Top module: `ptr_reg_access`

## Requirements
- R1: After reset, rd_valid, rd_byte, err_coef_ovf and err_burst_stat are 0. Every register and every coefficient reads 0x00. The pointer is 0.
- R2: In a write transaction (txn_start with txn_read=0), the first rx_valid byte loads the pointer and writes no storage.
- R3: While the pointer is nonzero, each following data byte is written to the register it selects and the pointer then advances by one. A burst of bytes therefore fills consecutive addresses.
- R4: The pointer advances from 255 to 1, never to 0. Writes to addresses at or above NUM_REGS (default 32) are discarded, and reads there return 0x00.
- R5: While the pointer is 0, data bytes fill coefficient slots 0, 1, 2, … in arrival order and the pointer does not change. The slot index restarts at 0 at every txn_start. coef_rd_data shows slot coef_rd_idx in the same cycle, and 0x00 for indices of 196 or more.
- R6: A coefficient byte arriving after all 196 slots of the current transaction are filled is discarded. err_coef_ovf is high for exactly the one cycle after that byte.
- R7: In a read transaction (txn_start with txn_read=1), each rd_req yields rd_valid=1 with the byte at the pointer in the following cycle, and the pointer then advances. At pointer 0 the byte is 0x00 and the pointer does not move.
- R8: Registers 12 and 13 ignore writes. Each bit of them is either clear-on-read (set by a high input bit and held until cleared) or live (the input bit registered once). COR mask defaults: 0xFF for register 12 and 0x0F for register 13.
- R9: A read of register 12 or 13 as the first read of a read transaction returns its value and clears its clear-on-read bits. An input bit set in the same cycle is kept.
- R10: A later read in the same transaction that reaches register 12 or 13 returns 0x00 with err_burst_stat=1 for that cycle. The register is not cleared, and the pointer still advances.
- R11: After txn_stop, rx_valid bytes and rd_req pulses are ignored until the next txn_start: no storage or pointer change, and rd_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Transaction start pulse |
| txn_read | input | 1 | Direction qualifier with txn_start (1 = read) |
| txn_stop | input | 1 | Transaction stop pulse |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Request for one read byte |
| rd_valid | output | 1 | Read byte valid, one cycle after rd_req |
| rd_byte | output | 8 | Read byte |
| stat_a_in | input | 8 | Event/level inputs of status register 12 |
| stat_b_in | input | 8 | Event/level inputs of status register 13 |
| coef_rd_idx | input | 8 | Coefficient read index |
| coef_rd_data | output | 8 | Coefficient at coef_rd_idx |
| err_coef_ovf | output | 1 | Pulse: coefficient byte beyond slot 195 dropped |
| err_burst_stat | output | 1 | Pulse: burst read reached a status register |

## Verification
The bench loads all 196 coefficients and then sends one extra byte. A design that counted slots off by one would either store the extra byte or flag the last real one. A second short coefficient load follows to confirm that the slot index restarts and the pointer stays at zero; a design that advanced the pointer would then return register 2 on the next read instead of 0x00. Further tests cover the 254→255→1 wrap, which a plain incrementer would turn into a coefficient write, and a burst read running into registers 12 and 13, where a faulty design would leak or clear status. The bench also reads register 13 twice to check that only its clear-on-read bits drop, and sends bytes after a stop that must change nothing.

// File: rtl/ptr_reg_access_pkg.sv
package ptr_reg_access_pkg;

    localparam int BYTE_W = 8;
    localparam int CIDX_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [BYTE_W-1:0]   ptr;
        logic [CIDX_W-1:0]   cidx;
        logic                first_rd;
        logic                rd_valid;
        logic [BYTE_W-1:0]   rd_byte;
        logic                err_ovf;
        logic                err_burst;
    } ctl_t;

    function automatic logic [BYTE_W-1:0] ptr_advance(input logic [BYTE_W-1:0] p);
        return (p == '1) ? BYTE_W'(1) : p + BYTE_W'(1);
    endfunction

endpackage

// File: rtl/pra_coef_mem.sv
module pra_coef_mem #(
    parameter int DEPTH = 196,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/pra_status_reg.sv
module pra_status_reg #(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] COR_MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_in,
    input  logic          rd_clr,
    output logic [DW-1:0] value
);

    logic [DW-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (rd_clr) begin
            val_d = val_d & ~COR_MASK;
        end
        val_d = ((val_d | evt_in) & COR_MASK) | (evt_in & ~COR_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign value = val_q;

endmodule

// File: rtl/ptr_reg_access.sv
module ptr_reg_access
    import ptr_reg_access_pkg::*;
#(
    parameter int          NUM_REGS    = 32,
    parameter int          COEF_DEPTH  = 196,
    parameter logic [7:0]  STAT_A_ADDR = 8'd12,
    parameter logic [7:0]  STAT_B_ADDR = 8'd13,
    parameter logic [7:0]  STAT_A_COR  = 8'hFF,
    parameter logic [7:0]  STAT_B_COR  = 8'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start,
    input  logic       txn_read,
    input  logic       txn_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [7:0] rd_byte,
    input  logic [7:0] stat_a_in,
    input  logic [7:0] stat_b_in,
    input  logic [7:0] coef_rd_idx,
    output logic [7:0] coef_rd_data,
    output logic       err_coef_ovf,
    output logic       err_burst_stat
);

    localparam int              RIW      = $clog2(NUM_REGS);
    localparam int              CAW      = $clog2(COEF_DEPTH);
    localparam logic [7:0]      NREG_B   = 8'(NUM_REGS);
    localparam logic [CIDX_W-1:0] CDEPTH_B = CIDX_W'(COEF_DEPTH);
    localparam int              NSTAT    = 2;
    localparam logic [NSTAT-1:0][7:0] COR_SEL  = {STAT_B_COR, STAT_A_COR};
    localparam logic [NSTAT-1:0][7:0] STAT_ADR = {STAT_B_ADDR, STAT_A_ADDR};

    ctl_t n, q;
    logic [NUM_REGS-1:0][7:0] regs_d, regs_q;

    logic                  coef_we;
    logic [7:0]            coef_mem_rd;
    logic [NSTAT-1:0]      stat_clr;
    logic [NSTAT-1:0][7:0] stat_val;
    logic [NSTAT-1:0][7:0] stat_evt;

    assign stat_evt = {stat_b_in, stat_a_in};

    // Status registers: one instance per status address
    for (genvar g = 0; g < NSTAT; g++) begin : g_stat
        pra_status_reg #(
            .DW       (8),
            .COR_MASK (COR_SEL[g])
        ) u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_in (stat_evt[g]),
            .rd_clr (stat_clr[g]),
            .value  (stat_val[g])
        );
    end

    pra_coef_mem #(
        .DEPTH (COEF_DEPTH),
        .DW    (8)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_idx  (q.cidx[CAW-1:0]),
        .wr_data (rx_byte),
        .rd_idx  (coef_rd_idx[CAW-1:0]),
        .rd_data (coef_mem_rd)
    );

    assign coef_rd_data = (coef_rd_idx < 8'(COEF_DEPTH)) ? coef_mem_rd : 8'h00;

    function automatic logic is_stat(input logic [7:0] a);
        return (a == STAT_A_ADDR) || (a == STAT_B_ADDR);
    endfunction

    always_comb begin
        n           = q;
        regs_d      = regs_q;
        n.rd_valid  = 1'b0;
        n.rd_byte   = 8'h00;
        n.err_ovf   = 1'b0;
        n.err_burst = 1'b0;
        coef_we     = 1'b0;
        stat_clr    = '0;

        if (txn_start) begin
            n.phase    = txn_read ? PH_RDATA : PH_ADDR;
            n.cidx     = '0;
            n.first_rd = 1'b1;
        end else if (txn_stop) begin
            n.phase = PH_IDLE;
        end else if (rx_valid) begin
            case (q.phase)
                PH_ADDR: begin
                    n.ptr   = rx_byte;
                    n.phase = PH_WDATA;
                end
                PH_WDATA: begin
                    if (q.ptr == 8'h00) begin
                        if (q.cidx < CDEPTH_B) begin
                            coef_we = 1'b1;
                            n.cidx  = q.cidx + CIDX_W'(1);
                        end else begin
                            n.err_ovf = 1'b1;
                        end
                    end else begin
                        if (q.ptr < NREG_B && !is_stat(q.ptr)) begin
                            regs_d[q.ptr[RIW-1:0]] = rx_byte;
                        end
                        n.ptr = ptr_advance(q.ptr);
                    end
                end
                default: ;
            endcase
        end else if (rd_req && q.phase == PH_RDATA) begin
            n.rd_valid = 1'b1;
            n.first_rd = 1'b0;
            if (q.ptr != 8'h00) begin
                n.ptr = ptr_advance(q.ptr);
                if (is_stat(q.ptr)) begin
                    for (int k = 0; k < NSTAT; k++) begin
                        if (q.ptr == STAT_ADR[k]) begin
                            if (q.first_rd) begin
                                n.rd_byte   = stat_val[k];
                                stat_clr[k] = 1'b1;
                            end else begin
                                n.err_burst = 1'b1;
                            end
                        end
                    end
                end else if (q.ptr < NREG_B) begin
                    n.rd_byte = regs_q[q.ptr[RIW-1:0]];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase     <= PH_IDLE;
            q.ptr       <= '0;
            q.cidx      <= '0;
            q.first_rd  <= 1'b0;
            q.rd_valid  <= 1'b0;
            q.rd_byte   <= '0;
            q.err_ovf   <= 1'b0;
            q.err_burst <= 1'b0;
            regs_q      <= '0;
        end else begin
            q      <= n;
            regs_q <= regs_d;
        end
    end

    assign rd_valid       = q.rd_valid;
    assign rd_byte        = q.rd_byte;
    assign err_coef_ovf   = q.err_ovf;
    assign err_burst_stat = q.err_burst;

endmodule

// File: rtl/ptr_reg_access_chk.sv
module ptr_reg_access_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txn_stop,
    input logic       rx_valid,
    input logic       rd_req,
    input logic       rd_valid,
    input logic [7:0] rd_byte,
    input logic [7:0] coef_rd_idx,
    input logic [7:0] coef_rd_data,
    input logic       err_coef_ovf,
    input logic       err_burst_stat
);

    AST_RD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req)); // R7

    AST_BURST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_burst_stat |-> (rd_valid && rd_byte == 8'h00)); // R10

    AST_OVF_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        err_coef_ovf |-> $past(rx_valid)); // R6

    AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rx_valid) && $stable(coef_rd_idx)) |-> $stable(coef_rd_data)); // R5

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        txn_stop |=> (!rd_valid && !err_coef_ovf)); // R11

endmodule

bind ptr_reg_access ptr_reg_access_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .txn_stop       (txn_stop),
    .rx_valid       (rx_valid),
    .rd_req         (rd_req),
    .rd_valid       (rd_valid),
    .rd_byte        (rd_byte),
    .coef_rd_idx    (coef_rd_idx),
    .coef_rd_data   (coef_rd_data),
    .err_coef_ovf   (err_coef_ovf),
    .err_burst_stat (err_burst_stat)
);

// File: tb/ptr_reg_access_bench.sv
module ptr_reg_access_bench;

    localparam int CLK_PERIOD = 10;

    // {address, write byte, expected read-back}
    localparam logic [23:0] VEC [8] = '{
        24'h02_11_11, 24'h07_C3_C3, 24'h1F_7E_7E, 24'h20_66_00,
        24'h0C_FF_00, 24'h0D_55_00, 24'h14_9A_9A, 24'h01_42_42
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 1'b0, txn_read = 1'b0, txn_stop = 1'b0;
    logic rx_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] stat_a_in = 8'h00, stat_b_in = 8'h00, coef_rd_idx = 8'h00;
    logic rd_valid, err_coef_ovf, err_burst_stat;
    logic [7:0] rd_byte, coef_rd_data;

    int n_checks = 0;
    int n_err = 0;
    logic done = 1'b0;
    logic v, e, o;
    logic [7:0] d;

    ptr_reg_access u_ptr_reg_access (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_read(txn_read),
        .txn_stop(txn_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .stat_a_in(stat_a_in), .stat_b_in(stat_b_in),
        .coef_rd_idx(coef_rd_idx), .coef_rd_data(coef_rd_data),
        .err_coef_ovf(err_coef_ovf), .err_burst_stat(err_burst_stat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic start_txn(input logic rd);
        txn_start = 1'b1; txn_read = rd;
        @(negedge clk);
        txn_start = 1'b0; txn_read = 1'b0;
    endtask

    task automatic stop_txn();
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_byte = 8'h00;
        o = err_coef_ovf;
    endtask

    task automatic read_byte();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_valid; d = rd_byte; e = err_burst_stat;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        start_txn(1'b0); send_byte(a); stop_txn();
    endtask

    task automatic read_at(input logic [7:0] a);
        set_ptr(a); start_txn(1'b1); read_byte(); stop_txn();
    endtask

    function automatic logic [7:0] coef_pat(input int i);
        return 8'(i * 3 + 7);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R1 errors", {6'd0, err_coef_ovf, err_burst_stat}, 8'h00);
        coef_rd_idx = 8'd5; #1;
        check("R1 coef slot 5", coef_rd_data, 8'h00);
        start_txn(1'b1);
        read_byte();
        check("R1 pointer 0 read valid", {7'd0, v}, 8'h01);
        check("R1 pointer 0 read byte", d, 8'h00);
        read_byte();
        check("R7 pointer 0 no advance", d, 8'h00);
        stop_txn();

        // R2/R3/R4/R8: vector table, write then read back
        for (int i = 0; i < 8; i++) begin
            start_txn(1'b0);
            send_byte(VEC[i][23:16]);
            send_byte(VEC[i][15:8]);
            stop_txn();
            read_at(VEC[i][23:16]);
            check($sformatf("R3 R2 R8 vector %0d addr %02h", i, VEC[i][23:16]), d, VEC[i][7:0]);
        end

        // R3: burst write to 3..5, R7: burst read back
        start_txn(1'b0);
        send_byte(8'h03); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
        stop_txn();
        set_ptr(8'h03);
        start_txn(1'b1);
        read_byte(); check("R7 burst byte 0", d, 8'hA1);
        read_byte(); check("R3 burst byte 1", d, 8'hA2);
        read_byte(); check("R3 burst byte 2", d, 8'hA3);
        stop_txn();

        // R4: wrap 254 -> 255 -> 1
        start_txn(1'b0);
        send_byte(8'hFE); send_byte(8'h10); send_byte(8'h20); send_byte(8'h30);
        stop_txn();
        read_at(8'h01);
        check("R4 wrap lands on reg 1", d, 8'h30);
        read_at(8'hFE);
        check("R4 out-of-range read valid", {7'd0, v}, 8'h01);
        check("R4 out-of-range read byte", d, 8'h00);

        // R5/R6: full coefficient load then one extra byte
        start_txn(1'b0);
        send_byte(8'h00);
        for (int i = 0; i < 196; i++) send_byte(coef_pat(i));
        check("R6 no flag at slot 195", {7'd0, o}, 8'h00);
        send_byte(8'hEE);
        check("R6 overflow flag", {7'd0, o}, 8'h01);
        @(negedge clk);
        check("R6 flag one cycle", {7'd0, err_coef_ovf}, 8'h00);
        stop_txn();
        coef_rd_idx = 8'd0;   #1; check("R5 coef slot 0", coef_rd_data, coef_pat(0));
        coef_rd_idx = 8'd100; #1; check("R5 coef slot 100", coef_rd_data, coef_pat(100));
        coef_rd_idx = 8'd195; #1; check("R6 coef slot 195 kept", coef_rd_data, coef_pat(195));
        coef_rd_idx = 8'd196; #1; check("R5 index 196 reads 0", coef_rd_data, 8'h00);

        // R5: index restart, pointer stays 0
        start_txn(1'b0);
        send_byte(8'h00); send_byte(8'h5C); send_byte(8'h5D);
        stop_txn();
        coef_rd_idx = 8'd0; #1; check("R5 restart slot 0", coef_rd_data, 8'h5C);
        coef_rd_idx = 8'd1; #1; check("R5 restart slot 1", coef_rd_data, 8'h5D);
        coef_rd_idx = 8'd2; #1; check("R5 slot 2 untouched", coef_rd_data, coef_pat(2));
        start_txn(1'b1);
        read_byte();
        check("R5 pointer not advanced", d, 8'h00);
        stop_txn();

        // R8/R9: status register 12 clear-on-read
        stat_a_in = 8'h05; @(negedge clk); stat_a_in = 8'h00;
        read_at(8'h0C); check("R9 status 12 first read", d, 8'h05);
        read_at(8'h0C); check("R9 status 12 cleared", d, 8'h00);

        // R8/R9: status register 13, low bits clear-on-read, high bits live
        stat_b_in = 8'h33; @(negedge clk); stat_b_in = 8'h30;
        read_at(8'h0D); check("R8 status 13 value", d, 8'h33);
        read_at(8'h0D); check("R9 status 13 partial clear", d, 8'h30);
        stat_b_in = 8'h00;

        // R10: burst read reaching status registers
        stat_a_in = 8'h81; @(negedge clk); stat_a_in = 8'h00;
        start_txn(1'b0); send_byte(8'h0B); send_byte(8'h5A); stop_txn();
        set_ptr(8'h0B);
        start_txn(1'b1);
        read_byte(); check("R7 reg 11 read", d, 8'h5A);
        check("R10 no error on reg 11", {7'd0, e}, 8'h00);
        read_byte(); check("R10 burst into 12 byte", d, 8'h00);
        check("R10 burst into 12 error", {7'd0, e}, 8'h01);
        read_byte(); check("R10 burst into 13 error", {7'd0, e}, 8'h01);
        read_byte(); check("R10 pointer advanced to 14", d, 8'h00);
        check("R10 no error on reg 14", {7'd0, e}, 8'h00);
        stop_txn();
        read_at(8'h0C); check("R10 status 12 not cleared", d, 8'h81);

        // R11: traffic after stop is ignored
        set_ptr(8'h03);
        send_byte(8'hEE);
        read_byte();
        check("R11 no read outside transaction", {7'd0, v}, 8'h00);
        start_txn(1'b1);
        read_byte();
        check("R11 reg 3 unchanged", d, 8'hA1);
        stop_txn();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule